// File: doc/BRIEF.md
# Partitioned Dependency-Matrix Issue Scheduler

This block holds renamed micro-ops between dispatch and execution. It is built as four independent partitions, one for each execution port, with capacities of 10, 10, 7 and 5 entries, which gives 32 entries in total. Every entry has a single global index: the partition's base plus the entry's local slot. With the default sizes the bases are 0, 10, 20 and 27.

Each entry keeps a row of wait bits, with one bit for each global index. A bit is set when the entry still waits on the producer at that index. An entry is ready when it is valid and its row is empty. Each partition records the dispatch order of its live entries. It scans the ready bits in that order through a two-level find-first-set tree with a radix of 6, and offers the oldest ready entry to its port. When the port's grant is high, the entry issues in that same cycle. At the following clock edge the entry is freed and its column is cleared in every row of every partition, so its consumers can issue one cycle later.

The dispatch logic sends each partition at most one micro-op per cycle, together with the global indices of its producers. Before dispatching, it reads the index that the new entry will take. A partition reports full when every slot is occupied. A flush input empties the whole scheduler at one clock edge.

Top module: `sched_matrix`

## Requirements
- R1: After reset, no partition issues even with every grant high, no partition reports full, and every disp_idx equals its partition base.
- R2: disp_idx for partition p (bits p*5 upward) equals the base of p plus the lowest free local slot, with bases 0, 10, 20 and 27. An accepted dispatch occupies exactly that slot.
- R3: A partition issues only in a cycle where its grant bit is high and it holds a ready entry. iss_valid and iss_idx are combinational in that cycle. An entry with an outstanding producer does not issue.
- R4: Among its ready entries, a partition issues the one dispatched earliest, whatever the slot numbers.
- R5: A consumer whose producer issues in cycle t can issue no earlier than cycle t+1, also when the two are in different partitions. An entry with two producers waits for both. Source s of partition p uses valid bit p*2+s and index bits (p*2+s)*5 upward.
- R6: A source whose producer index is not currently valid, or whose producer issues in the same cycle as the dispatch, adds no wait bit.
- R7: An issued entry is freed at the next edge and is never issued a second time.
- R8: disp_full[p] is high exactly when all slots of partition p are occupied. A dispatch request made while full is dropped.
- R9: A flush cycle removes every entry. In the next cycle nothing issues and no partition is full.
- R10: All four partitions can issue in the same cycle, and each issued index lies inside its own partition's range.
- R11: When a source's valid bit is low, its index is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Invalidate all entries at the next edge |
| disp_valid | input | 4 | Dispatch request, one bit per partition |
| disp_src_vld | input | 8 | Source valid, bit p*2+s |
| disp_src_idx | input | 40 | Producer global index, 5 bits for each source |
| grant | input | 4 | Execution port can accept an issue this cycle |
| disp_full | output | 4 | Partition has no free slot |
| disp_idx | output | 20 | Global index the next dispatch will take, 5 bits per partition |
| iss_valid | output | 4 | Partition issues this cycle |
| iss_idx | output | 20 | Global index of the issuing entry, 5 bits per partition |

## Verification
The bench fills every partition to capacity and checks the allocated indices and the full flag, then drains it to confirm that the extra dispatch attempt was dropped. A design that ignored full would issue one entry too many. It frees an old slot and refills it, so that age order and slot order disagree. A scan by index would then issue the refilled, younger entry first. Dependency cases span partitions, use two producers, and include a producer issuing in the dispatch cycle. These catch a wakeup that comes one cycle early, a lost second source, and a consumer stuck forever on a stale column bit. Flush is checked on full partitions, and four-way simultaneous issue is checked at the end.

// File: rtl/sched_matrix_pkg.sv
// Shared constants and parameter helpers for the partitioned scheduler.
package sched_matrix_pkg;
    localparam int unsigned NPART      = 4;
    localparam int unsigned DEF_DEPTH0 = 10;
    localparam int unsigned DEF_DEPTH1 = 10;
    localparam int unsigned DEF_DEPTH2 = 7;
    localparam int unsigned DEF_DEPTH3 = 5;

    // Capacity of partition p.
    function automatic int unsigned part_depth(input int unsigned p, input int unsigned d0,
                                               input int unsigned d1, input int unsigned d2,
                                               input int unsigned d3);
        case (p)
            0:       return d0;
            1:       return d1;
            2:       return d2;
            default: return d3;
        endcase
    endfunction

    // First global index of partition p (sum of the capacities below it).
    function automatic int unsigned part_base(input int unsigned p, input int unsigned d0,
                                              input int unsigned d1, input int unsigned d2);
        return (p > 0 ? d0 : 0) + (p > 1 ? d1 : 0) + (p > 2 ? d2 : 0);
    endfunction
endpackage

// File: rtl/sched_ffs.sv
// Find-first-set over W bits, with bit 0 taking priority.
// The bits are split into groups of RADIX. Each group resolves locally, and
// one priority stage then picks among the group results, so the depth is two
// levels. Assumes W <= RADIX*RADIX.
module sched_ffs #(
    parameter int unsigned W     = 10,
    parameter int unsigned RADIX = 6,
    localparam int unsigned NG   = (W + RADIX - 1) / RADIX,
    localparam int unsigned PW   = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [PW-1:0] pos
);
    logic [NG*RADIX-1:0] vpad;
    logic [NG-1:0]       g_any;
    logic [PW-1:0]       g_pos [NG];

    // Pad to whole groups and resolve the lowest set bit in each group.
    always_comb begin
        vpad = '0;
        vpad[W-1:0] = vec;
        for (int g = 0; g < NG; g++) begin
            g_any[g] = 1'b0;
            g_pos[g] = '0;
            for (int j = RADIX - 1; j >= 0; j--) begin
                if (vpad[g*RADIX+j]) begin
                    g_any[g] = 1'b1;
                    g_pos[g] = PW'(g*RADIX + j);
                end
            end
        end
    end

    // Second level: the lowest group that has any bit set wins.
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int g = NG - 1; g >= 0; g--) begin
            if (g_any[g]) begin
                found = 1'b1;
                pos   = g_pos[g];
            end
        end
    end
endmodule

// File: rtl/sched_part.sv
// One scheduler partition serving a single execution port.
// Every slot holds a valid bit and a row of wait bits over all global indices.
// An ordering list keeps the slot numbers of live entries, oldest first. The
// partition offers the oldest ready entry, and grant issues it in that cycle.
// Assumes a producer was dispatched in an earlier cycle than its consumers.
module sched_part #(
    parameter int unsigned DEPTH = 10,
    parameter int unsigned BASE  = 0,
    parameter int unsigned TOTAL = 32,
    parameter int unsigned NSRC  = 2,
    parameter int unsigned RADIX = 6,
    parameter int unsigned IW    = 5,
    localparam int unsigned LW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               disp_valid,
    input  logic [NSRC-1:0]    src_vld,
    input  logic [NSRC*IW-1:0] src_idx,
    input  logic [TOTAL-1:0]   glob_valid,
    input  logic [TOTAL-1:0]   col_clr,
    input  logic               grant,
    output logic               full,
    output logic [IW-1:0]      alloc_idx,
    output logic               iss_valid,
    output logic [IW-1:0]      iss_idx,
    output logic [DEPTH-1:0]   slot_valid,
    output logic [TOTAL-1:0]   col_mine
);
    logic [DEPTH-1:0] valid_q;
    logic [TOTAL-1:0] row_q [DEPTH];
    logic [LW-1:0]    ord_q [DEPTH];
    logic [CW-1:0]    cnt_q;

    logic [DEPTH-1:0] slot_rdy, age_rdy;
    logic             pick_found, accept, do_iss;
    logic [LW-1:0]    pick_pos, iss_slot, alloc_slot;
    logic [TOTAL-1:0] new_row;

    // Readiness by slot, then rearranged into age order for the picker.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) slot_rdy[i] = valid_q[i] && (row_q[i] == '0);
        for (int k = 0; k < DEPTH; k++) age_rdy[k] = (CW'(k) < cnt_q) && slot_rdy[ord_q[k]];
    end

    sched_ffs #(.W(DEPTH), .RADIX(RADIX)) u_ffs (
        .vec   (age_rdy),
        .found (pick_found),
        .pos   (pick_pos)
    );

    // Lowest free slot receives the next dispatch.
    always_comb begin
        alloc_slot = '0;
        for (int i = DEPTH - 1; i >= 0; i--) if (!valid_q[i]) alloc_slot = LW'(i);
    end

    // Wait row of a new entry: one bit per live producer that is not issuing now.
    always_comb begin
        new_row = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (src_vld[s] && glob_valid[src_idx[s*IW +: IW]] && !col_clr[src_idx[s*IW +: IW]])
                new_row[src_idx[s*IW +: IW]] = 1'b1;
        end
    end

    assign iss_slot   = ord_q[pick_pos];
    assign do_iss     = grant && pick_found;
    assign full       = &valid_q;
    assign accept     = disp_valid && !full;
    assign alloc_idx  = IW'(BASE) + IW'(alloc_slot);
    assign iss_valid  = do_iss;
    assign iss_idx    = IW'(BASE) + IW'(iss_slot);
    assign slot_valid = valid_q;
    assign col_mine   = do_iss ? ({{(TOTAL-1){1'b0}}, 1'b1} << (BASE + int'(iss_slot))) : '0;

    // State update: column wakeup, free on issue, fill on dispatch, reorder list.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid_q <= '0;
            cnt_q   <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                row_q[i] <= '0;
                ord_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) row_q[i] <= row_q[i] & ~col_clr;
            if (do_iss) valid_q[iss_slot] <= 1'b0;
            if (accept) begin
                valid_q[alloc_slot] <= 1'b1;
                row_q[alloc_slot]   <= new_row;
            end
            for (int k = 0; k < DEPTH - 1; k++)
                if (do_iss && LW'(k) >= pick_pos) ord_q[k] <= ord_q[k+1];
            if (accept) ord_q[cnt_q - CW'(do_iss)] <= alloc_slot;
            cnt_q <= cnt_q + CW'(accept) - CW'(do_iss);
        end
    end
endmodule

// File: rtl/sched_matrix.sv
// Top level of the partitioned scheduler: four partitions of unequal size.
// Each partition exports its valid slots and its issue column. The columns
// are ORed here and fed back to every partition, so any issue clears its wait
// bit scheduler-wide at the next edge.
module sched_matrix
    import sched_matrix_pkg::*;
#(
    parameter int unsigned DEPTH0 = DEF_DEPTH0,
    parameter int unsigned DEPTH1 = DEF_DEPTH1,
    parameter int unsigned DEPTH2 = DEF_DEPTH2,
    parameter int unsigned DEPTH3 = DEF_DEPTH3,
    parameter int unsigned NSRC   = 2,
    parameter int unsigned RADIX  = 6,
    localparam int unsigned TOTAL = DEPTH0 + DEPTH1 + DEPTH2 + DEPTH3,
    localparam int unsigned IW    = $clog2(TOTAL)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic [NPART-1:0]         disp_valid,
    input  logic [NPART*NSRC-1:0]    disp_src_vld,
    input  logic [NPART*NSRC*IW-1:0] disp_src_idx,
    input  logic [NPART-1:0]         grant,
    output logic [NPART-1:0]         disp_full,
    output logic [NPART*IW-1:0]      disp_idx,
    output logic [NPART-1:0]         iss_valid,
    output logic [NPART*IW-1:0]      iss_idx
);
    logic [TOTAL-1:0] glob_valid;
    logic [TOTAL-1:0] col_clr;
    logic [TOTAL-1:0] col_part [NPART];

    // Merge the per-partition issue columns into one clear vector.
    always_comb begin
        col_clr = '0;
        for (int p = 0; p < NPART; p++) col_clr = col_clr | col_part[p];
    end

    for (genvar p = 0; p < NPART; p++) begin : g_part
        localparam int unsigned DEPTH = part_depth(p, DEPTH0, DEPTH1, DEPTH2, DEPTH3);
        localparam int unsigned BASE  = part_base(p, DEPTH0, DEPTH1, DEPTH2);
        logic [DEPTH-1:0] sv;

        sched_part #(
            .DEPTH(DEPTH), .BASE(BASE), .TOTAL(TOTAL),
            .NSRC(NSRC), .RADIX(RADIX), .IW(IW)
        ) u_part (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (flush),
            .disp_valid (disp_valid[p]),
            .src_vld    (disp_src_vld[p*NSRC +: NSRC]),
            .src_idx    (disp_src_idx[p*NSRC*IW +: NSRC*IW]),
            .glob_valid (glob_valid),
            .col_clr    (col_clr),
            .grant      (grant[p]),
            .full       (disp_full[p]),
            .alloc_idx  (disp_idx[p*IW +: IW]),
            .iss_valid  (iss_valid[p]),
            .iss_idx    (iss_idx[p*IW +: IW]),
            .slot_valid (sv),
            .col_mine   (col_part[p])
        );

        assign glob_valid[BASE +: DEPTH] = sv;
    end
endmodule

// File: rtl/sched_matrix_chk.sv
// Property checker for sched_matrix, attached through bind below.
// Looks only at the top-level ports.
module sched_matrix_chk
    import sched_matrix_pkg::*;
#(
    parameter int unsigned DEPTH0 = DEF_DEPTH0,
    parameter int unsigned DEPTH1 = DEF_DEPTH1,
    parameter int unsigned DEPTH2 = DEF_DEPTH2,
    parameter int unsigned DEPTH3 = DEF_DEPTH3,
    parameter int unsigned IW     = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                flush,
    input logic [NPART-1:0]    grant,
    input logic [NPART-1:0]    disp_full,
    input logic [NPART*IW-1:0] disp_idx,
    input logic [NPART-1:0]    iss_valid,
    input logic [NPART*IW-1:0] iss_idx
);
    for (genvar p = 0; p < NPART; p++) begin : g_chk
        localparam int DEPTH = int'(part_depth(p, DEPTH0, DEPTH1, DEPTH2, DEPTH3));
        localparam int BASE  = int'(part_base(p, DEPTH0, DEPTH1, DEPTH2));

        AST_NO_GRANT_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
            !grant[p] |-> !iss_valid[p]); // R3
        AST_ISSUE_IN_PART: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[p] |-> (int'(iss_idx[p*IW +: IW]) >= BASE &&
                              int'(iss_idx[p*IW +: IW]) < BASE + DEPTH)); // R10
        AST_ALLOC_IN_PART: assert property (@(posedge clk) disable iff (!rst_n)
            !disp_full[p] |-> (int'(disp_idx[p*IW +: IW]) >= BASE &&
                               int'(disp_idx[p*IW +: IW]) < BASE + DEPTH)); // R2
        AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[p] && !flush |=>
                !(iss_valid[p] && iss_idx[p*IW +: IW] == $past(iss_idx[p*IW +: IW]))); // R7
        AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            disp_full[p] && !iss_valid[p] && !flush |=> disp_full[p]); // R8
        AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
            flush |=> !disp_full[p] && !iss_valid[p]); // R9
    end
endmodule

bind sched_matrix sched_matrix_chk #(
    .DEPTH0(DEPTH0), .DEPTH1(DEPTH1), .DEPTH2(DEPTH2), .DEPTH3(DEPTH3), .IW(IW)
) u_chk (.*);

// File: tb/sched_matrix_test.sv
`timescale 1ns/1ps
// Self-checking bench: drives inputs and samples just after the falling edge.
module sched_matrix_test;
    logic        clk = 1'b0;
    logic        rst_n, flush;
    logic [3:0]  disp_valid, grant, disp_full, iss_valid;
    logic [7:0]  disp_src_vld;
    logic [39:0] disp_src_idx;
    logic [19:0] disp_idx, iss_idx;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sched_matrix uut (.*);

    // Expected geometry, computed from the partition sizes.
    function automatic int dep(int p); return (p < 2) ? 10 : (p == 2 ? 7 : 5); endfunction
    function automatic int bas(int p);
        int b = 0;
        for (int q = 0; q < p; q++) b += dep(q);
        return b;
    endfunction
    function automatic int didx(int p); return int'(disp_idx[p*5 +: 5]); endfunction
    function automatic int iidx(int p); return int'(iss_idx[p*5 +: 5]); endfunction

    task automatic chk(int act, int exp, string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        disp_valid = '0; disp_src_vld = '0; disp_src_idx = '0; flush = 1'b0;
    endtask

    task automatic put(int p, bit v0, int i0, bit v1, int i1);
        disp_valid[p] = 1'b1;
        disp_src_vld[2*p] = v0;
        disp_src_vld[2*p+1] = v1;
        disp_src_idx[(2*p)*5 +: 5] = 5'(i0);
        disp_src_idx[(2*p+1)*5 +: 5] = 5'(i1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int exp_order[3];
        rst_n = 1'b0; grant = '0; idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        grant = 4'hf; #1;
        chk(int'(iss_valid), 0, "R1 no issue after reset");
        chk(int'(disp_full), 0, "R1 not full after reset");
        for (int p = 0; p < 4; p++) chk(didx(p), bas(p), "R1 alloc at base");
        @(negedge clk); grant = '0;

        // R2/R8/R4/R7 fill every partition, try an extra dispatch, then drain
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < dep(p); k++) begin
                idle(); put(p, 0, 0, 0, 0); #1;
                chk(didx(p), bas(p) + k, "R2 alloc index");
                chk(int'(disp_full[p]), 0, "R8 not yet full");
                @(negedge clk);
            end
            idle(); #1;
            chk(int'(disp_full[p]), 1, "R8 full flag");
            put(p, 0, 0, 0, 0);
            @(negedge clk);
            idle(); grant[p] = 1'b1;
            for (int k = 0; k < dep(p) + 2; k++) begin
                #1;
                if (k < dep(p)) begin
                    chk(int'(iss_valid[p]), 1, "R4 drain valid");
                    chk(iidx(p), bas(p) + k, "R4 drain order");
                end else begin
                    chk(int'(iss_valid[p]), 0, "R8 dropped dispatch / R7 no reissue");
                end
                @(negedge clk);
            end
            grant = '0;
        end

        // R4 age order differs from slot order
        for (int k = 0; k < 3; k++) begin idle(); put(3, 0, 0, 0, 0); @(negedge clk); end
        idle(); grant[3] = 1'b1; #1;
        chk(iidx(3), 27, "R4 oldest first");
        @(negedge clk); grant = '0;
        put(3, 0, 0, 0, 0); #1;
        chk(didx(3), 27, "R2 reuse freed slot");
        @(negedge clk); idle(); grant[3] = 1'b1;
        exp_order = '{28, 29, 27};
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(int'(iss_valid[3]), 1, "R4 age valid");
            chk(iidx(3), exp_order[k], "R4 age order");
            @(negedge clk);
        end
        #1; chk(int'(iss_valid[3]), 0, "R7 partition drained");
        @(negedge clk); grant = '0;

        // R3/R5 dependency across partitions
        idle(); put(0, 0, 0, 0, 0); @(negedge clk);
        idle(); put(2, 1, 0, 0, 0); #1;
        chk(didx(2), 20, "R2 consumer slot");
        @(negedge clk); idle();
        grant = 4'b0100; #1;
        chk(int'(iss_valid[2]), 0, "R3 waiting entry blocked");
        @(negedge clk); grant = 4'hf; #1;
        chk(int'(iss_valid), 1, "R5 only producer issues");
        chk(iidx(0), 0, "R5 producer index");
        @(negedge clk); #1;
        chk(int'(iss_valid), 4, "R5 consumer wakes next cycle");
        chk(iidx(2), 20, "R5 consumer index");
        @(negedge clk); #1;
        chk(int'(iss_valid), 0, "R7 nothing left");
        @(negedge clk); grant = '0;

        // R5 two producers
        idle(); put(0, 0, 0, 0, 0); put(1, 0, 0, 0, 0); @(negedge clk);
        idle(); put(3, 1, 0, 1, 10); #1;
        chk(didx(3), 27, "R2 two-source slot");
        @(negedge clk); idle();
        grant = 4'b0001; #1; chk(iidx(0), 0, "R5 first producer");
        @(negedge clk); grant = 4'b1000; #1;
        chk(int'(iss_valid[3]), 0, "R5 still waits on second source");
        @(negedge clk); grant = 4'b0010; #1; chk(iidx(1), 10, "R5 second producer");
        @(negedge clk); grant = 4'b1000; #1;
        chk(int'(iss_valid[3]), 1, "R5 both sources done");
        chk(iidx(3), 27, "R5 two-source index");
        @(negedge clk); grant = '0;

        // R6 producer issuing in dispatch cycle, and producer not valid
        idle(); put(0, 0, 0, 0, 0); @(negedge clk);
        idle(); put(1, 1, 0, 1, 5); grant = 4'b0001; #1;
        chk(iidx(0), 0, "R6 producer issues now");
        chk(didx(1), 10, "R6 consumer slot");
        @(negedge clk); idle(); grant = 4'b0010; #1;
        chk(int'(iss_valid[1]), 1, "R6 no stale wait bit");
        chk(iidx(1), 10, "R6 consumer index");
        @(negedge clk); grant = '0;

        // R11 source valid low ignores index of a live producer
        idle(); put(0, 0, 0, 0, 0); @(negedge clk);
        idle(); put(1, 0, 0, 0, 0); @(negedge clk);
        idle(); grant = 4'b0010; #1;
        chk(int'(iss_valid[1]), 1, "R11 masked source ignored");
        chk(iidx(1), 10, "R11 index");
        @(negedge clk); grant = '0;

        // R9 flush with full partition and a leftover entry
        for (int k = 0; k < 5; k++) begin idle(); put(3, 0, 0, 0, 0); put(2, 0, 0, 0, 0); @(negedge clk); end
        idle(); #1; chk(int'(disp_full[3]), 1, "R8 full before flush");
        flush = 1'b1; @(negedge clk);
        flush = 1'b0; grant = 4'hf; #1;
        chk(int'(iss_valid), 0, "R9 nothing after flush");
        chk(int'(disp_full), 0, "R9 no full after flush");
        for (int p = 0; p < 4; p++) chk(didx(p), bas(p), "R9 alloc at base");
        @(negedge clk); grant = '0;

        // R10 simultaneous issue from all partitions
        idle(); for (int p = 0; p < 4; p++) put(p, 0, 0, 0, 0);
        @(negedge clk); idle(); grant = 4'hf; #1;
        chk(int'(iss_valid), 15, "R10 four issues");
        for (int p = 0; p < 4; p++) chk(iidx(p), bas(p), "R10 per-partition index");
        @(negedge clk); #1;
        chk(int'(iss_valid), 0, "R7 freed after issue");
        @(negedge clk); grant = '0;

        finish_run();
    end
endmodule